// File: doc/BRIEF.md
# Serial Display Command Decoder

This block sits between a host's serial link and the scan logic of a multiplexed segment display. The host clocks 8-bit words in, MSB first, while holding an active-low select. Each word that begins a selection is read by its top bits. It can load the display RAM write address, load the first command register (duty code, display enable, shift-digit count) or load the second command register (the character index that starts the scan). Once an address word has been seen, every further word in the same selection is display data. Each data word is written at the current address, and the address then steps up by one.

The serial pins are sampled by the system clock through a synchronizer, so the serial clock must stay well below the system clock. The address counter is five bits wide and the display RAM holds thirty bytes. The counter therefore walks through two slots that do not exist before it wraps to zero, and data aimed at those slots produces no write.

The RAM write port is a single-cycle strobe with address and data. It has no ready input: the serial link cannot be stalled, so the RAM must accept a write in any cycle. Both command registers drive plain level outputs.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After reset, duty code is 000, display enable is 0, shift-digit code is 000, start character is 0001, and no write strobe is issued.
- R2: Bits are taken MSB first on each rising serial clock edge while select is low, and a word is complete after the eighth such edge. Serial clock edges while select is high are ignored.
- R3: Raising select discards a partly received word, and the next complete word is read as the first word of a new selection.
- R4: A first word with bits 7:6 = 00 loads bits 4:0 into the write address. Bit 5 is ignored and no write is issued.
- R5: After an address word, every further word in the same selection is written at the current address, and the address then increments by one.
- R6: The address is 5 bits and wraps from 1F to 00. A data word arriving while the address is 1E or 1F (reached by increment or loaded directly) issues no write but still advances the address.
- R7: A first word with bit 7 = 1 loads bits 6:0 into command register 1: bits 6:4 are the duty code, bit 3 is display enable and bits 2:0 are the shift-digit code.
- R8: A first word with bits 7:6 = 01 loads bits 3:0 as the start character. Bits 5:4 are ignored.
- R9: A start character value of 1111 is rejected, and the start character keeps its previous value.
- R10: After a command word (R7 or R8), the next word of the same selection is again read as a first word.
- R11: Each stored data word gives exactly one write strobe cycle, which carries the address and the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Active-low select; high ends a selection |
| ram_wr_en | output | 1 | Display RAM write strobe, one cycle |
| ram_wr_addr | output | 5 | Display RAM write address |
| ram_wr_data | output | 8 | Display RAM write data |
| duty_code | output | 3 | Duty code from command register 1 |
| disp_on | output | 1 | Display enable from command register 1 |
| shift_code | output | 3 | Shift-digit code from command register 1 |
| init_char | output | 4 | Start character from command register 2 |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 30 RAM slots and a two-stage synchronizer. With these values a run of data words from address 1C crosses the missing slots 1E and 1F and wraps to 00 within a few words, so the dropped writes and the wrap are both observed at the write port. A serial bit period of eight system clocks leaves margin over the synchronizer delay. This allows aborted partial words, and serial clock pulses sent while select is high, to be placed between ordinary selections.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  localparam int WORD_W  = 8;
  localparam int DUTY_W  = 3;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    WK_ADDR = 2'd0,
    WK_CR2  = 2'd1,
    WK_CR1  = 2'd2
  } word_kind_e;

  typedef struct packed {
    logic [DUTY_W-1:0]  duty;
    logic               disp_on;
    logic [SHIFT_W-1:0] shift;
  } cr1_t;

  localparam cr1_t CR1_RST = '{duty: '0, disp_on: 1'b0, shift: '0};

  function automatic word_kind_e classify(input logic [WORD_W-1:0] w);
    if (w[WORD_W-1])      return WK_CR1;
    else if (w[WORD_W-2]) return WK_CR2;
    else                  return WK_ADDR;
  endfunction
endpackage

// File: rtl/disp_serial_rx.sv
module disp_serial_rx
  import disp_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_sel_n,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              sel_idle
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  // pin order within each stage: {select, data, clock}
  logic [2:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b100;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= {ser_sel_n, ser_dat, ser_clk};
    end
  end

  logic sclk_s, dat_s, sel_s, sclk_d, rise;
  assign sclk_s   = stg[SYNC_STAGES-1][0];
  assign dat_s    = stg[SYNC_STAGES-1][1];
  assign sel_s    = stg[SYNC_STAGES-1][2];
  assign sel_idle = sel_s;
  assign rise     = sclk_s & ~sclk_d & ~sel_s;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      word_vld <= 1'b0;
      if (sel_s) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= {sh[WORD_W-2:0], dat_s};
        if (cnt == LAST_BIT) begin
          cnt      <= '0;
          word     <= {sh[WORD_W-2:0], dat_s};
          word_vld <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: a completed word is reported for a single cycle only
  a_r2_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  // R3: an idle select clears the bit position and yields no word
  a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (cnt == '0 && !word_vld));
endmodule

// File: rtl/disp_frame_decoder.sv
module disp_frame_decoder
  import disp_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter int          CHAR_W   = 4,
  parameter logic [3:0]  CHAR_RST = 4'd1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_vld,
  input  logic [WORD_W-1:0]  word,
  input  logic               sel_idle,
  output logic               addr_load,
  output logic [ADDR_W-1:0]  addr_val,
  output logic               data_wr,
  output logic [WORD_W-1:0]  data_val,
  output cr1_t               cr1,
  output logic [CHAR_W-1:0]  init_char
);
  localparam logic [CHAR_W-1:0] CHAR_BAD = '1;

  logic       data_mode;
  word_kind_e kind;
  logic       cr1_ld, cr2_ld;

  always_comb begin
    kind      = classify(word);
    addr_load = word_vld & ~data_mode & (kind == WK_ADDR);
    cr1_ld    = word_vld & ~data_mode & (kind == WK_CR1);
    cr2_ld    = word_vld & ~data_mode & (kind == WK_CR2);
    data_wr   = word_vld & data_mode;
    addr_val  = word[ADDR_W-1:0];
    data_val  = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_mode <= 1'b0;
    else if (sel_idle)  data_mode <= 1'b0;
    else if (addr_load) data_mode <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr1       <= CR1_RST;
      init_char <= CHAR_W'(CHAR_RST);
    end else begin
      if (cr1_ld) cr1 <= cr1_t'(word[WORD_W-2:0]);
      if (cr2_ld && word[CHAR_W-1:0] != CHAR_BAD) init_char <= word[CHAR_W-1:0];
    end
  end

  // R7: command register 1 changes only on a load
  a_r7_cr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cr1_ld |=> $stable(cr1));
  // R8: an accepted start character appears on the next cycle
  a_r8_cr2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cr2_ld && word[CHAR_W-1:0] != CHAR_BAD) |=> init_char == $past(word[CHAR_W-1:0]));
  // R9: the rejected code never reaches the output
  a_r9_char_legal: assert property (@(posedge clk) disable iff (!rst_n)
    init_char != CHAR_BAD);
  // R10: a command word leaves the decoder expecting a first word
  a_r10_cmd_keeps_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1_ld || cr2_ld) |=> !data_mode);
endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr
  import disp_cmd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int RAM_DEPTH = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] data_val,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic [WORD_W-1:0] ram_wr_data
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(RAM_DEPTH);

  logic [ADDR_W-1:0] addr_q;
  logic              in_range;
  assign in_range = {1'b0, addr_q} < DEPTH_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      ram_wr_en   <= 1'b0;
      ram_wr_addr <= '0;
      ram_wr_data <= '0;
    end else begin
      ram_wr_en <= 1'b0;
      if (addr_load) begin
        addr_q <= addr_val;
      end else if (data_wr) begin
        addr_q <= addr_q + ADDR_W'(1);
        if (in_range) begin
          ram_wr_en   <= 1'b1;
          ram_wr_addr <= addr_q;
          ram_wr_data <= data_val;
        end
      end
    end
  end

  // R4: an address word sets the counter
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> addr_q == $past(addr_val));
  // R5: each data word advances the counter by one, wrapping
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_load) |=> addr_q == $past(addr_q) + ADDR_W'(1));
  // R6: data at a slot past the RAM end produces no strobe
  a_r6_drop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !in_range) |=> !ram_wr_en);
  // R11: a strobe lasts one cycle
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |=> !ram_wr_en);
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
  import disp_cmd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int RAM_DEPTH   = 30,
  parameter int SYNC_STAGES = 2,
  parameter int CHAR_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_sel_n,
  output logic               ram_wr_en,
  output logic [ADDR_W-1:0]  ram_wr_addr,
  output logic [WORD_W-1:0]  ram_wr_data,
  output logic [DUTY_W-1:0]  duty_code,
  output logic               disp_on,
  output logic [SHIFT_W-1:0] shift_code,
  output logic [CHAR_W-1:0]  init_char
);
  logic              word_vld, sel_idle;
  logic [WORD_W-1:0] word;
  logic              addr_load, data_wr;
  logic [ADDR_W-1:0] addr_val;
  logic [WORD_W-1:0] data_val;
  cr1_t              cr1;

  disp_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_sel_n(ser_sel_n),
    .word_vld(word_vld), .word(word), .sel_idle(sel_idle)
  );

  disp_frame_decoder #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .word_vld(word_vld), .word(word), .sel_idle(sel_idle),
    .addr_load(addr_load), .addr_val(addr_val),
    .data_wr(data_wr), .data_val(data_val),
    .cr1(cr1), .init_char(init_char)
  );

  disp_addr_ctr #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .addr_load(addr_load), .addr_val(addr_val),
    .data_wr(data_wr), .data_val(data_val),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
  );

  assign duty_code  = cr1.duty;
  assign disp_on    = cr1.disp_on;
  assign shift_code = cr1.shift;
endmodule

// File: tb/tb_disp_cmd_decoder.sv
module tb_disp_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel_n = 1'b1;
  logic       ram_wr_en;
  logic [4:0] ram_wr_addr;
  logic [7:0] ram_wr_data;
  logic [2:0] duty_code, shift_code;
  logic       disp_on;
  logic [3:0] init_char;

  always #2 clk = ~clk;

  disp_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_sel_n(ser_sel_n),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .duty_code(duty_code), .disp_on(disp_on), .shift_code(shift_code),
    .init_char(init_char)
  );

  typedef struct { logic [4:0] a; logic [7:0] d; } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // bench model, built from the requirements
  bit         m_first;
  logic [4:0] m_addr = '0;
  logic [2:0] m_duty = 3'b000, m_shift = 3'b000;
  logic       m_on = 1'b0;
  logic [3:0] m_char = 4'd1;

  task automatic chk(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "duty_code", duty_code, m_duty);
    chk(req, "disp_on", disp_on, m_on);
    chk(req, "shift_code", shift_code, m_shift);
    chk(req, "init_char", init_char, m_char);
  endtask

  // scoreboard monitor: R11 one strobe per stored word with addr and data
  always @(negedge clk) begin
    if (rst_n && ram_wr_en && !done) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6/R11 unexpected write actual=%0h:%0h expected=none",
                 ram_wr_addr, ram_wr_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (ram_wr_addr !== e.a || ram_wr_data !== e.d) begin
          bad++;
          $display("FAIL R5/R11 write actual=%0h:%0h expected=%0h:%0h",
                   ram_wr_addr, ram_wr_data, e.a, e.d);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic frame_begin();
    @(negedge clk) ser_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    m_first = 1;
  endtask

  task automatic frame_end();
    repeat (6) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] b);
    if (m_first) begin
      if (b[7]) begin
        m_duty = b[6:4]; m_on = b[3]; m_shift = b[2:0];
      end else if (b[6]) begin
        if (b[3:0] != 4'hF) m_char = b[3:0];
      end else begin
        m_addr = b[4:0]; m_first = 0;
      end
    end else begin
      if (m_addr < 5'd30) exp_q.push_back('{a: m_addr, d: b});
      m_addr = m_addr + 5'd1;
    end
    send_bits(b, 8);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset values
    check_regs("R1");
    chk("R1", "ram_wr_en", ram_wr_en, 0);

    // R7 then R10 and R8: command word followed by a second command word
    frame_begin(); send_word(8'hB5); send_word(8'h77); frame_end();
    check_regs("R7/R8/R10");
    frame_begin(); send_word(8'hC9); frame_end();
    check_regs("R7");

    // R9 start character 1111 rejected
    frame_begin(); send_word(8'h7F); frame_end();
    check_regs("R9");
    chk("R9", "init_char kept", init_char, 7);

    // R4 address with bit 5 set, R5 sequential data
    frame_begin(); send_word(8'h23); send_word(8'h11); send_word(8'h22); send_word(8'h33); frame_end();
    chk("R5", "pending writes", exp_q.size(), 0);

    // R6 run across 1E/1F and the wrap to 00
    frame_begin();
    send_word(8'h1C); send_word(8'hA1); send_word(8'hA2); send_word(8'hA3);
    send_word(8'hA4); send_word(8'hA5); send_word(8'hA6);
    frame_end();
    chk("R6", "pending writes", exp_q.size(), 0);

    // R6 explicit load of 1E: first two data words dropped
    frame_begin(); send_word(8'h1E); send_word(8'h5C); send_word(8'h6D); send_word(8'h7E); frame_end();
    chk("R6", "pending writes", exp_q.size(), 0);

    // R3 partial word aborted, next word is a first word
    frame_begin(); send_bits(8'hFF, 5); frame_end();
    check_regs("R3");
    frame_begin(); send_word(8'h52); frame_end();
    check_regs("R3");
    frame_begin(); send_word(8'h05); send_word(8'hAA); send_bits(8'h33, 4); frame_end();
    frame_begin(); send_word(8'h9F); frame_end();
    check_regs("R3");
    chk("R3", "pending writes", exp_q.size(), 0);

    // R2 serial clock pulses with select high are ignored
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    repeat (12) @(negedge clk);
    check_regs("R2");
    frame_begin(); send_word(8'h46); frame_end();
    check_regs("R2");
    chk("R2", "init_char", init_char, 6);

    repeat (10) @(negedge clk);
    chk("R11", "leftover writes", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule